// File: doc/BRIEF.md
# Instruction Format Decoder

This block sits between instruction fetch and execute in a small 32-bit core with sixteen general registers and 16-bit instruction halfwords. Each accepted halfword is split into a format class, an operation code, up to two register numbers and an extended short immediate. The block also reports the instruction length and flags any encoding that is not assigned. The two top bits of the halfword pick one of three layouts: register/register, register plus 8-bit immediate, and conditional branch.

Some register/register operations carry a 32-bit word immediately after the halfword, which makes them six bytes long. For those the decoder raises `ext_needed` in the same cycle the halfword is offered, so that fetch can start on the following word at once. The decoder then waits and keeps the word when `ext_valid` arrives. The decoded result is released with a one-cycle `decode_valid` strobe only when it is complete. An unassigned encoding is reported through `illegal_out`, and every other decoded field is then replaced by the values of a no-operation.

Top module: `ifd_decoder`

## Requirements
- R1: After reset `decode_valid`, `ext_needed` (with `insn_valid` low), `illegal_out` and `has_ext_out` are 0, and `fmt_out`, `op_out`, `imm_out` and `ext_word_out` are all zero.
- R2: A halfword with bit 15 clear is class 1 (register/register). Bits 15:14 equal to 2'b10 give class 2 (immediate). Bits 15:14 equal to 2'b11 give class 3 (branch). `fmt_out` carries the class number.
- R3: In class 1, `op_out` is bits 15:8, `ra_out` is bits 7:4, `rb_out` is bits 3:0 and `imm_out` is 0.
- R4: In class 2, `op_out` is bits 13:12 zero-extended (0 add, 1 subtract, 2 read special register, 3 write special register). `ra_out` is bits 11:8, `rb_out` is 0 and `imm_out` is bits 7:0 zero-extended to 32 bits.
- R5: In class 3, `op_out` is the condition in bits 13:10, and `ra_out` and `rb_out` are 0. `imm_out` is the byte offset: bits 9:0 taken as a signed word count, multiplied by two and sign-extended to 32 bits.
- R6: Class 1 codes 0x01, 0x03, 0x08, 0x09, 0x0C, 0x0D, 0x1A, 0x1B, 0x1D, 0x1F, 0x20, 0x22, 0x24, 0x30 and 0x36 to 0x39 report `len_out` = 6 and `has_ext_out` = 1. Every other legal encoding reports `len_out` = 2 and `has_ext_out` = 0.
- R7: `ext_needed` is high in the cycle a six-byte halfword is offered and stays high until the extension word is taken. A word offered with `ext_valid` while waiting gives `decode_valid` on the next cycle, with `ext_word_out` equal to that word. A two-byte instruction gives `decode_valid` on the cycle after it is offered, with `ext_word_out` = 0.
- R8: Class 1 codes 0x0F to 0x18 and 0x3A to 0x7F, and class 3 conditions 10 to 15, set `illegal_out`. Such an encoding also forces `fmt_out` = 1, `op_out`, `ra_out`, `rb_out` and `imm_out` to 0, `len_out` = 2 and `has_ext_out` = 0, and it never waits for an extension word.
- R9: `insn_valid` is ignored while an extension word is awaited. `ext_valid` is ignored while none is awaited.
- R10: `decode_valid` is a one-cycle strobe per instruction. The decoded outputs hold their values until the next instruction is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | A halfword is offered on `insn` |
| insn | input | 16 | Instruction halfword |
| ext_valid | input | 1 | The 32-bit word following the halfword is offered |
| ext_word | input | 32 | Extension word |
| ext_needed | output | 1 | The offered or pending instruction needs an extension word |
| decode_valid | output | 1 | One-cycle strobe: decoded outputs are complete |
| fmt_out | output | 2 | Format class 1, 2 or 3 (0 only after reset) |
| op_out | output | 8 | Operation code, sub-operation or branch condition |
| ra_out | output | 4 | First register field |
| rb_out | output | 4 | Second register field |
| imm_out | output | 32 | Extended short immediate or branch byte offset |
| len_out | output | 3 | Instruction length in bytes, 2 or 6 |
| has_ext_out | output | 1 | A 32-bit word follows the halfword |
| illegal_out | output | 1 | Unassigned encoding |
| ext_word_out | output | 32 | Captured extension word |

## Verification
The assertions assume that the fetch side drives `insn_valid` and `ext_valid` to known levels from reset onward. The capture property also treats any `ext_valid` seen during a wait as the genuine word for the pending instruction. The bench offers every one of the 65,536 halfwords and answers each `ext_needed` with a distinct word. It sometimes delays that answer, and it raises the ignored strobes only at chosen points: a stray `insn_valid` during a wait, or a stray `ext_valid` alongside a new halfword. That exercises R9 without ever feeding a second word to one instruction.

// File: rtl/ifd_pkg.sv
package ifd_pkg;

    localparam int HW_W      = 16;
    localparam int DATA_W    = 32;
    localparam int REG_W     = 4;
    localparam int OP_W      = 8;
    localparam int LEN_W     = 3;
    localparam int SHORT_LEN = 2;
    localparam int LONG_LEN  = 6;
    localparam int F1_SPAN   = 64;
    localparam int F1_IDX_W  = $clog2(F1_SPAN);
    localparam int F1_LAST   = 'h39;
    localparam int F1_HOLE_LO = 'h0F;
    localparam int F1_HOLE_HI = 'h18;
    localparam int BR_CONDS  = 10;
    localparam int COND_W    = 4;
    localparam int SUB_W     = 2;
    localparam int OFF_W     = 10;
    localparam int IMM8_W    = 8;

    typedef enum logic [1:0] {
        FMT_NONE = 2'd0,
        FMT_REG  = 2'd1,
        FMT_IMM  = 2'd2,
        FMT_BR   = 2'd3
    } fmt_e;

    typedef struct packed {
        fmt_e              fmt;
        logic [OP_W-1:0]   op;
        logic [REG_W-1:0]  ra;
        logic [REG_W-1:0]  rb;
        logic [DATA_W-1:0] imm;
        logic [LEN_W-1:0]  len;
        logic              has_ext;
        logic              illegal;
    } dec_t;

    typedef struct packed {
        logic              waiting;
        logic              dv;
        dec_t              dec;
        logic [DATA_W-1:0] ext;
    } state_t;

    function automatic logic f1_assigned(int code);
        return (code < F1_HOLE_LO) || (code > F1_HOLE_HI && code <= F1_LAST);
    endfunction

    function automatic logic f1_carries_word(int code);
        case (code)
            'h01, 'h03, 'h08, 'h09, 'h0C, 'h0D, 'h1A, 'h1B,
            'h1D, 'h1F, 'h20, 'h22, 'h24, 'h30,
            'h36, 'h37, 'h38, 'h39: return 1'b1;
            default:                return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/ifd_fields.sv
module ifd_fields
    import ifd_pkg::*;
(
    input  logic [HW_W-1:0]   hw,
    output fmt_e              fmt,
    output logic [OP_W-1:0]   op,
    output logic [REG_W-1:0]  ra,
    output logic [REG_W-1:0]  rb,
    output logic [DATA_W-1:0] imm
);

    localparam int BR_PAD  = DATA_W - OFF_W - 1;
    localparam int IMM_PAD = DATA_W - IMM8_W;

    always_comb begin
        fmt = FMT_REG;
        op  = '0;
        ra  = '0;
        rb  = '0;
        imm = '0;
        if (!hw[15]) begin
            fmt = FMT_REG;
            op  = hw[15:8];
            ra  = hw[7:4];
            rb  = hw[3:0];
        end else if (hw[14]) begin
            fmt = FMT_BR;
            op  = {{(OP_W-COND_W){1'b0}}, hw[13:10]};
            imm = {{BR_PAD{hw[OFF_W-1]}}, hw[OFF_W-1:0], 1'b0};
        end else begin
            fmt = FMT_IMM;
            op  = {{(OP_W-SUB_W){1'b0}}, hw[13:12]};
            ra  = hw[11:8];
            imm = {{IMM_PAD{1'b0}}, hw[IMM8_W-1:0]};
        end
    end

endmodule

// File: rtl/ifd_legal.sv
module ifd_legal
    import ifd_pkg::*;
(
    input  logic [7:0] code_hi,
    output logic       legal,
    output logic       long_form
);

    logic [F1_SPAN-1:0] assigned_map;
    logic [F1_SPAN-1:0] word_map;

    for (genvar c = 0; c < F1_SPAN; c++) begin : g_map
        assign assigned_map[c] = f1_assigned(c);
        assign word_map[c]     = f1_carries_word(c);
    end

    logic [F1_IDX_W-1:0] idx;
    assign idx = code_hi[F1_IDX_W-1:0];

    always_comb begin
        legal     = 1'b1;
        long_form = 1'b0;
        if (!code_hi[7]) begin
            legal     = !code_hi[6] && assigned_map[idx];
            long_form = !code_hi[6] && word_map[idx];
        end else if (code_hi[6]) begin
            legal = int'(code_hi[5:2]) < BR_CONDS;
        end
    end

endmodule

// File: rtl/ifd_decoder.sv
module ifd_decoder
    import ifd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_valid,
    input  logic [HW_W-1:0]   insn,
    input  logic              ext_valid,
    input  logic [DATA_W-1:0] ext_word,
    output logic              ext_needed,
    output logic              decode_valid,
    output logic [1:0]        fmt_out,
    output logic [OP_W-1:0]   op_out,
    output logic [REG_W-1:0]  ra_out,
    output logic [REG_W-1:0]  rb_out,
    output logic [DATA_W-1:0] imm_out,
    output logic [LEN_W-1:0]  len_out,
    output logic              has_ext_out,
    output logic              illegal_out,
    output logic [DATA_W-1:0] ext_word_out
);

    fmt_e              raw_fmt;
    logic [OP_W-1:0]   raw_op;
    logic [REG_W-1:0]  raw_ra;
    logic [REG_W-1:0]  raw_rb;
    logic [DATA_W-1:0] raw_imm;
    logic              legal;
    logic              long_form;

    ifd_fields u_fields (
        .hw  (insn),
        .fmt (raw_fmt),
        .op  (raw_op),
        .ra  (raw_ra),
        .rb  (raw_rb),
        .imm (raw_imm)
    );

    ifd_legal u_legal (
        .code_hi   (insn[15:8]),
        .legal     (legal),
        .long_form (long_form)
    );

    dec_t   dec_c;
    state_t st_d, st_q;
    logic   wait_q;

    always_comb begin
        if (legal) begin
            dec_c.fmt     = raw_fmt;
            dec_c.op      = raw_op;
            dec_c.ra      = raw_ra;
            dec_c.rb      = raw_rb;
            dec_c.imm     = raw_imm;
            dec_c.len     = long_form ? LEN_W'(LONG_LEN) : LEN_W'(SHORT_LEN);
            dec_c.has_ext = long_form;
            dec_c.illegal = 1'b0;
        end else begin
            dec_c.fmt     = FMT_REG;
            dec_c.op      = '0;
            dec_c.ra      = '0;
            dec_c.rb      = '0;
            dec_c.imm     = '0;
            dec_c.len     = LEN_W'(SHORT_LEN);
            dec_c.has_ext = 1'b0;
            dec_c.illegal = 1'b1;
        end
    end

    always_comb begin
        st_d    = st_q;
        st_d.dv = 1'b0;
        if (st_q.waiting) begin
            if (ext_valid) begin
                st_d.ext     = ext_word;
                st_d.waiting = 1'b0;
                st_d.dv      = 1'b1;
            end
        end else if (insn_valid) begin
            st_d.dec = dec_c;
            st_d.ext = '0;
            if (dec_c.has_ext) begin
                st_d.waiting = 1'b1;
            end else begin
                st_d.dv = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wait_q       = st_q.waiting;
    assign ext_needed   = st_q.waiting | (insn_valid & dec_c.has_ext);
    assign decode_valid = st_q.dv;
    assign fmt_out      = st_q.dec.fmt;
    assign op_out       = st_q.dec.op;
    assign ra_out       = st_q.dec.ra;
    assign rb_out       = st_q.dec.rb;
    assign imm_out      = st_q.dec.imm;
    assign len_out      = st_q.dec.len;
    assign has_ext_out  = st_q.dec.has_ext;
    assign illegal_out  = st_q.dec.illegal;
    assign ext_word_out = st_q.ext;

endmodule

// File: rtl/ifd_checker.sv
module ifd_checker
    import ifd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              waiting,
    input logic              ext_valid,
    input logic [DATA_W-1:0] ext_word,
    input logic              ext_needed,
    input logic              decode_valid,
    input logic [1:0]        fmt_out,
    input logic [OP_W-1:0]   op_out,
    input logic [REG_W-1:0]  ra_out,
    input logic [REG_W-1:0]  rb_out,
    input logic [DATA_W-1:0] imm_out,
    input logic [LEN_W-1:0]  len_out,
    input logic              has_ext_out,
    input logic              illegal_out,
    input logic [DATA_W-1:0] ext_word_out
);

    a_r7_needed_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        waiting |-> ext_needed);

    a_r7_word_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && ext_valid) |=> (decode_valid && has_ext_out
                                    && len_out == LEN_W'(LONG_LEN)
                                    && ext_word_out == $past(ext_word)));

    a_r9_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && !ext_valid) |=> (waiting && !decode_valid
                                     && $stable(op_out) && $stable(fmt_out)));

    a_r8_illegal_is_nop: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_out |-> (fmt_out == 2'd1 && op_out == '0 && ra_out == '0
                         && rb_out == '0 && imm_out == '0
                         && len_out == LEN_W'(SHORT_LEN) && !has_ext_out));

    a_r6_len_matches_ext: assert property (@(posedge clk) disable iff (!rst_n)
        decode_valid |-> (has_ext_out == (len_out == LEN_W'(LONG_LEN))));

    a_r5_branch_cond_range: assert property (@(posedge clk) disable iff (!rst_n)
        (decode_valid && fmt_out == 2'd3) |-> (int'(op_out) < BR_CONDS));

    a_r4_imm_zero_extended: assert property (@(posedge clk) disable iff (!rst_n)
        (decode_valid && fmt_out == 2'd2) |-> (imm_out[DATA_W-1:IMM8_W] == '0));

endmodule

bind ifd_decoder ifd_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .waiting      (wait_q),
    .ext_valid    (ext_valid),
    .ext_word     (ext_word),
    .ext_needed   (ext_needed),
    .decode_valid (decode_valid),
    .fmt_out      (fmt_out),
    .op_out       (op_out),
    .ra_out       (ra_out),
    .rb_out       (rb_out),
    .imm_out      (imm_out),
    .len_out      (len_out),
    .has_ext_out  (has_ext_out),
    .illegal_out  (illegal_out),
    .ext_word_out (ext_word_out)
);

// File: tb/ifd_decoder_test.sv
module ifd_decoder_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid = 1'b0;
    logic [15:0] insn = '0;
    logic        ext_valid = 1'b0;
    logic [31:0] ext_word = '0;
    logic        ext_needed, decode_valid, has_ext_out, illegal_out;
    logic [1:0]  fmt_out;
    logic [7:0]  op_out;
    logic [3:0]  ra_out, rb_out;
    logic [31:0] imm_out, ext_word_out;
    logic [2:0]  len_out;

    int compared = 0;
    int mismatched = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ifd_decoder uut (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
        .ext_valid(ext_valid), .ext_word(ext_word), .ext_needed(ext_needed),
        .decode_valid(decode_valid), .fmt_out(fmt_out), .op_out(op_out),
        .ra_out(ra_out), .rb_out(rb_out), .imm_out(imm_out), .len_out(len_out),
        .has_ext_out(has_ext_out), .illegal_out(illegal_out),
        .ext_word_out(ext_word_out)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h (insn 0x%04h)",
                     req, what, act, exp, insn);
        end
    endtask

    // Expected decode computed from the requirement text
    typedef struct {
        int fmt, op, ra, rb, len, hasx, ill;
        logic [31:0] imm;
        string req;
    } exp_t;

    function automatic exp_t model(int h);
        exp_t e;
        int top, code, off;
        logic ok;
        top = h / 16384;
        e.imm = 0; e.ra = 0; e.rb = 0; e.len = 2; e.hasx = 0; ok = 1;
        if (top < 2) begin
            code = h / 256;
            e.fmt = 1; e.op = code; e.ra = (h / 16) % 16; e.rb = h % 16; e.req = "R3";
            ok = (code <= 14) || (code >= 25 && code <= 57);
            case (code)
                1, 3, 8, 9, 12, 13, 26, 27, 29, 31, 32, 36, 48, 54, 55, 56, 57: begin
                    e.len = 6; e.hasx = 1;
                end
                34: begin e.len = 6; e.hasx = 1; end
                default: ;
            endcase
        end else if (top == 2) begin
            e.fmt = 2; e.op = (h / 4096) % 4; e.ra = (h / 256) % 16;
            e.imm = 32'(h % 256); e.req = "R4";
        end else begin
            e.fmt = 3; e.op = (h / 1024) % 16; e.req = "R5";
            ok = e.op < 10;
            off = h % 1024;
            if (off >= 512) off = off - 1024;
            e.imm = 32'(off * 2);
        end
        e.ill = ok ? 0 : 1;
        if (!ok) begin
            e.fmt = 1; e.op = 0; e.ra = 0; e.rb = 0; e.imm = 0;
            e.len = 2; e.hasx = 0; e.req = "R8";
        end
        return e;
    endfunction

    task automatic compare_fields(exp_t e);
        check(e.req, "fmt", 32'(fmt_out), 32'(e.fmt));
        check(e.req, "op", 32'(op_out), 32'(e.op));
        check(e.req, "ra", 32'(ra_out), 32'(e.ra));
        check(e.req, "rb", 32'(rb_out), 32'(e.rb));
        check(e.req, "imm", imm_out, e.imm);
        check("R6", "len", 32'(len_out), 32'(e.len));
        check("R6", "has_ext", 32'(has_ext_out), 32'(e.hasx));
        check("R8", "illegal", 32'(illegal_out), 32'(e.ill));
    endtask

    // Offer one halfword; answer an extension request, optionally with stray strobes
    task automatic run_insn(int h, logic [31:0] w, int stall, bit stray_ext);
        exp_t e;
        e = model(h);
        @(negedge clk);
        insn = 16'(h); insn_valid = 1'b1;
        ext_valid = stray_ext; ext_word = ~w;
        #1;
        check("R7", "ext_needed on offer", 32'(ext_needed), 32'(e.hasx));
        @(negedge clk);
        insn_valid = 1'b0; ext_valid = 1'b0;
        if (e.hasx != 0) begin
            check("R7", "valid before word", 32'(decode_valid), 0);
            check("R7", "ext_needed waiting", 32'(ext_needed), 1);
            for (int s = 0; s < stall; s++) begin
                insn = 16'h0200; insn_valid = 1'b1;   // r9_ stray halfword while waiting
                @(negedge clk);
                insn_valid = 1'b0;
                check("R9", "still waiting", 32'(ext_needed), 1);
                check("R9", "no strobe", 32'(decode_valid), 0);
            end
            ext_valid = 1'b1; ext_word = w;
            @(negedge clk);
            ext_valid = 1'b0;
            check("R7", "valid after word", 32'(decode_valid), 1);
            check("R7", "ext_word_out", ext_word_out, w);
        end else begin
            check("R7", "valid short", 32'(decode_valid), 1);
            check("R9", "ext_word_out short", ext_word_out, 0);
        end
        compare_fields(e);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", "decode_valid", 32'(decode_valid), 0);
        check("R1", "ext_needed", 32'(ext_needed), 0);
        check("R1", "fmt", 32'(fmt_out), 0);
        check("R1", "op", 32'(op_out), 0);
        check("R1", "illegal", 32'(illegal_out), 0);
        check("R1", "has_ext", 32'(has_ext_out), 0);
        check("R1", "imm", imm_out, 0);
        check("R1", "ext_word_out", ext_word_out, 0);

        // R2 R3 R4 R5 R6 R8: sweep every halfword
        for (int h = 0; h < 65536; h++) begin
            run_insn(h, 32'hA500_0000 ^ 32'(h * 7919), (h % 5 == 0) ? 1 : 0, (h % 7 == 0));
        end

        // R10: strobe lasts one cycle and fields hold while idle
        run_insn('h0529, 32'h0, 0, 1'b0);
        @(negedge clk);
        check("R10", "strobe dropped", 32'(decode_valid), 0);
        check("R10", "op held", 32'(op_out), 32'h05);
        check("R10", "rb held", 32'(rb_out), 32'h9);

        // R9: stray word while idle changes nothing
        ext_valid = 1'b1; ext_word = 32'hDEAD_BEEF;
        @(negedge clk);
        ext_valid = 1'b0;
        check("R9", "no strobe on stray word", 32'(decode_valid), 0);
        check("R9", "ext_word_out unchanged", ext_word_out, 0);

        // R7: long wait then capture, with a stray word on the offer cycle
        run_insn('h3012, 32'h1234_5678, 3, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule